// File: doc/BRIEF.md
# Energy-Window Photon Counting Pixel

This block is the digital part of one pixel in a hybrid X-ray readout matrix. Two discriminator levels, low and high, arrive already synchronized to the pixel clock. A photon is counted only if its pulse lies inside the energy window between the two thresholds. The pulse must cross the low threshold and must not reach the high one. The event is taken when the low-discriminator pulse ends. It counts only if the high discriminator was quiet for the whole pulse.

The count is held in a maximal-length pseudo-random register (an LFSR), not in a binary counter, so each count step costs a single XNOR. When the shutter is closed, the same flip-flops become a shift-register stage. Pixels can then be chained for serial readout, and the count is also available as a parallel word at all times. An 8-bit configuration word is shifted in through the same serial path. It holds a mask bit, a test-enable bit and two 3-bit threshold trim codes, which are only presented as digital outputs. A parameter selects a wider variant whose counter stops at its terminal state instead of wrapping.

Top module: `window_count_pixel`

## Requirements
- R1: After reset the count register is 0, all configuration bits are 0 (trim_lo = 0, trim_hi = 0, unmasked, test off), and ser_out is 0.
- R2: An event is counted on the cycle in which the low-discriminator pulse ends, and only if disc_hi was low on every cycle of that pulse. Each counted event advances the counter by exactly one LFSR step, and disc_hi without a low pulse has no effect.
- R3: One LFSR step maps state s to {s[W-2:0], fb}, where fb is the inverted XOR of the tap bits. For W = 13 the taps are 12, 3, 2 and 0, and for W = 14 they are 13, 4, 2 and 0. From the reset state 0 the sequence visits every value except all-ones.
- R4: An event is counted only when shutter_open is 1 in the cycle the pulse ends. With the shutter closed the count changes only through shifting.
- R5: Configuration bit 0 is the mask. When it is 1, no event is counted.
- R6: Configuration bit 1 is test enable. When it is 1, test_pulse takes the place of disc_lo and disc_hi is ignored. When it is 0, test_pulse has no effect.
- R7: With shutter_open = 0, shift_en = 1 and cfg_sel = 1, the configuration word shifts as cfg <= {cfg[6:0], ser_in}, and ser_out shows cfg[7]. trim_lo is cfg[4:2] and trim_hi is cfg[7:5]. The count does not change.
- R8: With shutter_open = 0, shift_en = 1 and cfg_sel = 0, the count shifts as cnt <= {cnt[W-2:0], ser_in}, and ser_out shows cnt[W-1], most significant bit first. The configuration does not change.
- R9: While shutter_open = 1, shift_en changes neither the count nor the configuration.
- R10: count_word always shows the present count register.
- R11: The terminal state is 1 << (W-1), which is the state just before 0 in the sequence. With SATURATE = 0 an event there wraps the count to 0. With SATURATE = 1 the count stays at the terminal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shutter_open | input | 1 | 1: acquisition (counting), 0: shifting allowed |
| disc_lo | input | 1 | Low-threshold discriminator level |
| disc_hi | input | 1 | High-threshold discriminator level |
| test_pulse | input | 1 | Test stimulus used in place of disc_lo when test enable is set |
| shift_en | input | 1 | Shift one bit this cycle (shutter closed only) |
| cfg_sel | input | 1 | 1: shift path is the configuration word, 0: the counter |
| ser_in | input | 1 | Serial input from the previous pixel |
| ser_out | output | 1 | Serial output to the next pixel |
| count_word | output | CNT_W | Parallel view of the count register |
| trim_lo | output | 3 | Low-threshold trim code |
| trim_hi | output | 3 | High-threshold trim code |

## Verification
The counting path is driven with these patterns:
- clean low pulses of several lengths, including a single cycle;
- low pulses with a high-threshold excursion in the middle and on the final cycle;
- high-threshold activity with no low pulse.

Together these separate a window detector from a plain edge counter and show where the veto window ends. The same pulses are repeated with the shutter closed, with the pixel masked, and in test mode, where disc_lo must be ignored and disc_hi must not veto. This shows which source actually drives the count.

Counts are decoded against an independent LFSR model and read back both in parallel and serially. Loaded terminal states separate the wrapping variant from the saturating one.

// File: rtl/wpix_pkg.sv
package wpix_pkg;
  localparam int CFG_W        = 8;
  localparam int TRIM_W       = 3;
  localparam int CFG_MASK_BIT = 0;
  localparam int CFG_TEST_BIT = 1;
  localparam int CFG_TLO_LSB  = 2;
  localparam int CFG_THI_LSB  = 5;

  // Feedback tap set for a maximal-length sequence of the given width.
  function automatic logic [31:0] tap_mask(input int w);
    case (w)
      13:      return 32'h0000_100D;
      14:      return 32'h0000_2015;
      16:      return 32'h0000_D008;
      default: return 32'h0000_00B8;
    endcase
  endfunction

  // One XNOR-feedback step; the all-zero state is part of the sequence.
  function automatic logic [31:0] lfsr_next(input logic [31:0] s, input int w);
    logic [31:0] keep;
    logic        fb;
    keep = (32'h1 << w) - 32'h1;
    fb   = ~(^(s & tap_mask(w)));
    return ((s << 1) | {31'd0, fb}) & keep;
  endfunction
endpackage

// File: rtl/win_detect.sv
module win_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_in,
  input  logic veto_in,
  output logic evt
);
  logic hit_q;
  logic veto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      veto_q <= 1'b0;
    end else begin
      hit_q  <= hit_in;
      veto_q <= hit_in & (veto_q | veto_in);
    end
  end

  // Pulse has ended and no veto was seen on any of its cycles.
  assign evt = hit_q & ~hit_in & ~veto_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/lfsr_shift_count.sv
module lfsr_shift_count #(
  parameter int W        = 13,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         at_term
);
  import wpix_pkg::*;
  localparam logic [W-1:0] TERM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] nxt;
  logic         hold;

  assign nxt     = W'(lfsr_next(32'(q), W));
  assign at_term = (q == TERM);

  generate
    if (SATURATE) begin : g_sat
      assign hold = at_term;
    end else begin : g_wrap
      assign hold = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)               q <= '0;
    else if (shift)           q <= {q[W-2:0], sin};
    else if (step && !hold)   q <= nxt;
  end
endmodule

// File: rtl/window_count_pixel.sv
module window_count_pixel #(
  parameter int CNT_W    = 13,
  parameter bit SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shutter_open,
  input  logic             disc_lo,
  input  logic             disc_hi,
  input  logic             test_pulse,
  input  logic             shift_en,
  input  logic             cfg_sel,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [CNT_W-1:0] count_word,
  output logic [2:0]       trim_lo,
  output logic [2:0]       trim_hi
);
  import wpix_pkg::*;

  logic [CFG_W-1:0] cfg_word;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_src, veto_src, win_evt, cnt_step;
  logic             shift_cnt, shift_cfg, at_term;

  assign hit_src   = cfg_word[CFG_TEST_BIT] ? test_pulse : disc_lo;
  assign veto_src  = cfg_word[CFG_TEST_BIT] ? 1'b0       : disc_hi;
  assign cnt_step  = win_evt & shutter_open & ~cfg_word[CFG_MASK_BIT];
  assign shift_cnt = shift_en & ~shutter_open & ~cfg_sel;
  assign shift_cfg = shift_en & ~shutter_open &  cfg_sel;

  win_detect u_win (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_src), .veto_in(veto_src), .evt(win_evt)
  );

  cfg_shift_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .shift(shift_cfg), .sin(ser_in), .q(cfg_word)
  );

  lfsr_shift_count #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .shift(shift_cnt), .sin(ser_in),
    .q(cnt_q), .at_term(at_term)
  );

  assign count_word = cnt_q;
  assign ser_out    = cfg_sel ? cfg_word[CFG_W-1] : cnt_q[CNT_W-1];
  assign trim_lo    = cfg_word[CFG_TLO_LSB +: TRIM_W];
  assign trim_hi    = cfg_word[CFG_THI_LSB +: TRIM_W];
endmodule

// File: rtl/window_count_pixel_chk.sv
module window_count_pixel_chk #(
  parameter int CNT_W    = 13,
  parameter bit SATURATE = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shutter_open,
  input logic             shift_en,
  input logic             cfg_sel,
  input logic             ser_in,
  input logic             win_evt,
  input logic             at_term,
  input logic [CNT_W-1:0] count_word,
  input logic [7:0]       cfg_word
);
  // R4
  closed_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutter_open && !(shift_en && !cfg_sel)) |=> $stable(count_word));
  // R2
  no_event_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutter_open && !win_evt) |=> $stable(count_word));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutter_open && cfg_word[0]) |=> $stable(count_word));
  // R9
  open_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_open |=> $stable(cfg_word));
  // R8
  cnt_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutter_open && shift_en && !cfg_sel) |=>
      (count_word == {$past(count_word[CNT_W-2:0]), $past(ser_in)}));
  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && shutter_open && at_term) |=> at_term);
endmodule

bind window_count_pixel window_count_pixel_chk #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutter_open(shutter_open), .shift_en(shift_en),
  .cfg_sel(cfg_sel), .ser_in(ser_in), .win_evt(win_evt), .at_term(at_term),
  .count_word(count_word), .cfg_word(cfg_word)
);

// File: tb/window_count_pixel_test.sv
module window_count_pixel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic shutter_open = 0, disc_lo = 0, disc_hi = 0, test_pulse = 0;
  logic shift_en = 0, cfg_sel = 0, ser_in = 0;
  logic ser_out, ser_out_s;
  logic [12:0] cnt13;
  logic [13:0] cnt14;
  logic [2:0]  tlo, thi, tlo_s, thi_s;

  int errs = 0, checks = 0;
  logic [31:0] exp13 = 0, exp14 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window_count_pixel uut (
    .clk(clk), .rst_n(rst_n), .shutter_open(shutter_open), .disc_lo(disc_lo),
    .disc_hi(disc_hi), .test_pulse(test_pulse), .shift_en(shift_en), .cfg_sel(cfg_sel),
    .ser_in(ser_in), .ser_out(ser_out), .count_word(cnt13), .trim_lo(tlo), .trim_hi(thi));

  window_count_pixel #(.CNT_W(14), .SATURATE(1'b1)) uut_sat (
    .clk(clk), .rst_n(rst_n), .shutter_open(shutter_open), .disc_lo(disc_lo),
    .disc_hi(disc_hi), .test_pulse(test_pulse), .shift_en(shift_en), .cfg_sel(cfg_sel),
    .ser_in(ser_in), .ser_out(ser_out_s), .count_word(cnt14), .trim_lo(tlo_s), .trim_hi(thi_s));

  // Independent model of one sequence step (R3).
  function automatic logic [31:0] model_step(input logic [31:0] s, input int w);
    logic fb;
    if (w == 13) fb = ~(s[12] ^ s[3] ^ s[2] ^ s[0]);
    else         fb = ~(s[13] ^ s[4] ^ s[2] ^ s[0]);
    return ((s << 1) | {31'd0, fb}) & ((32'h1 << w) - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_counts(input string tag);
    check(cnt13 == exp13[12:0], {tag, " cnt13"}, 32'(cnt13), exp13);
    check(cnt14 == exp14[13:0], {tag, " cnt14"}, 32'(cnt14), exp14);
  endtask

  task automatic count_expected();
    exp13 = model_step(exp13, 13);
    if (exp14 != 32'h2000) exp14 = model_step(exp14, 14);
  endtask

  // Pulse of len cycles on disc_lo (or test_pulse); disc_hi high on cycle hi_at.
  task automatic pulse(input int len, input int hi_at, input bit use_test);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (use_test) test_pulse = 1; else disc_lo = 1;
      disc_hi = (i == hi_at);
    end
    @(negedge clk);
    disc_lo = 0; test_pulse = 0; disc_hi = 0;
    @(negedge clk);
  endtask

  task automatic shift_in(input logic [31:0] v, input int n, input bit sel);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      shift_en = 1; cfg_sel = sel; ser_in = v[i];
    end
    @(negedge clk);
    shift_en = 0; ser_in = 0;
  endtask

  task automatic t_reset();
    check(cnt13 == 0 && cnt14 == 0, "R1 count reset", 32'(cnt13), 0);
    check(tlo == 0 && thi == 0, "R1 trim reset", {26'd0, thi, tlo}, 0);
    check(ser_out == 0, "R1 ser_out reset", 32'(ser_out), 0);
  endtask

  task automatic t_window();
    shutter_open = 1;
    for (int k = 1; k <= 5; k++) begin
      pulse(k, -1, 0);
      count_expected();
    end
    check_counts("R2 R3 clean pulses");
    check(cnt13 == exp13[12:0], "R10 parallel word", 32'(cnt13), exp13);
    pulse(4, 2, 0);
    check_counts("R2 veto mid pulse");
    pulse(3, 2, 0);
    check_counts("R2 veto last cycle");
    @(negedge clk); disc_hi = 1; @(negedge clk); @(negedge clk); disc_hi = 0; @(negedge clk);
    check_counts("R2 hi without lo");
    pulse(1, -1, 0); count_expected();
    check_counts("R2 single-cycle pulse");
  endtask

  task automatic t_shutter();
    @(negedge clk); shutter_open = 0;
    pulse(2, -1, 0);
    check_counts("R4 shutter closed");
  endtask

  task automatic t_config();
    logic [7:0] got;
    shift_in(32'h98, 8, 1);
    check(tlo == 3'd6 && thi == 3'd4, "R7 trim fields", {26'd0, thi, tlo}, 32'h26);
    check_counts("R7 count held during cfg shift");
    got = 0;
    cfg_sel = 1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); got[i] = ser_out; shift_en = 1; ser_in = 0;
    end
    @(negedge clk); shift_en = 0;
    check(got == 8'h98, "R7 cfg serial out", 32'(got), 32'h98);
  endtask

  task automatic t_mask();
    shift_in(32'h01, 8, 1);
    @(negedge clk); shutter_open = 1;
    pulse(3, -1, 0);
    check_counts("R5 masked");
    @(negedge clk); shutter_open = 0;
  endtask

  task automatic t_test_mode();
    shift_in(32'h02, 8, 1);
    @(negedge clk); shutter_open = 1;
    pulse(3, -1, 0);
    check_counts("R6 disc_lo ignored in test");
    pulse(3, 1, 1); count_expected();
    check_counts("R6 test pulse counted, hi ignored");
    @(negedge clk); shutter_open = 0;
    shift_in(32'h00, 8, 1);
    @(negedge clk); shutter_open = 1;
    pulse(2, -1, 1);
    check_counts("R6 test pulse ignored when off");
  endtask

  task automatic t_open_shift();
    shift_in(32'h7, 3, 1);
    check(tlo == 0 && thi == 0, "R9 cfg held while open", {26'd0, thi, tlo}, 0);
    shift_in(32'h5, 3, 0);
    check_counts("R9 count held while open");
    @(negedge clk); shutter_open = 0;
  endtask

  task automatic t_readout();
    logic [13:0] g13, g14;
    g13 = 0; g14 = 0;
    cfg_sel = 0;
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk);
      if (i >= 1) g13[i-1] = ser_out;
      g14[i] = ser_out_s;
      shift_en = 1; ser_in = 0;
    end
    @(negedge clk); shift_en = 0;
    check(g13[12:0] == exp13[12:0], "R8 serial readout 13", 32'(g13), exp13);
    check(g14 == exp14[13:0], "R8 serial readout 14", 32'(g14), exp14);
    exp13 = 0; exp14 = 0;
    check_counts("R8 cleared by shifting zeros");
  endtask

  task automatic t_terminal();
    shift_in(32'h1000, 13, 0);
    exp13 = 32'h1000; exp14 = 32'h1000;
    check_counts("R8 parallel load");
    @(negedge clk); shutter_open = 1;
    pulse(2, -1, 0);
    exp13 = 0; exp14 = model_step(32'h1000, 14);
    check_counts("R11 wrap at terminal");
    @(negedge clk); shutter_open = 0;
    shift_in(32'h2000, 14, 0);
    exp13 = 0; exp14 = 32'h2000;
    @(negedge clk); shutter_open = 1;
    pulse(2, -1, 0); count_expected();
    pulse(1, -1, 0); count_expected();
    check_counts("R11 saturate holds");
    @(negedge clk); shutter_open = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_shutter();
    t_config();
    t_mask();
    t_test_mode();
    t_open_shift();
    t_readout();
    t_terminal();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule